// File: doc/BRIEF.md
# Signed Integer to Hexadecimal Floating-Point Converter

This block turns a 32-bit two's-complement integer into a normalized 64-bit base-16 floating-point word. The result word carries a sign bit, a 7-bit characteristic that is the power-of-sixteen exponent stored with an offset of 64, and a 56-bit fraction made of fourteen hex digits. The fraction is held as a magnitude, so a negative number differs from its positive counterpart only in the sign bit.

The converter does not count leading zeros on the magnitude of the input. It inverts the integer's top bit, which maps the signed range onto 0 to 2^32-1. It places that biased value as an unnormalized float whose characteristic makes the fraction read as a whole number. It then subtracts 2^31 at the same characteristic and normalizes the difference one hex digit per characteristic step. A caller offers an integer with a valid/ready handshake. The result appears on a valid-qualified output after a fixed latency. Only one conversion is in flight at a time.

Top module: `int_to_hexfloat`

## Requirements
- R1: The result word is laid out as bit 63 = sign, bits 62:56 = characteristic (offset 64), bits 55:0 = fraction, most significant hex digit in bits 55:52; for example 59 converts to 0x423B000000000000.
- R2: A positive input yields sign 0 and an exact, normalized value: the leading fraction digit is nonzero and fraction × 16^(characteristic − 78) equals the input.
- R3: A negative input yields sign 1, with characteristic and fraction identical to those of its absolute value (for example −1 gives 0xC110000000000000).
- R4: An input of zero yields the all-zero word (sign 0, characteristic 0, fraction 0).
- R5: The range ends convert exactly: −2^31 gives 0xC880000000000000 and 2^31−1 gives 0x487FFFFFFF000000.
- R6: An input accepted on clock edge n (in_valid and in_ready both high) raises out_valid at edge n+2, and out_valid stays high for exactly one cycle.
- R7: in_ready is low from the edge that accepts an input until the edge that raises out_valid. in_data offered while in_ready is low is ignored: it produces no result and does not change the pending one.
- R8: During and right after reset, in_ready is 1, out_valid is 0 and out_data is 0.
- R9: out_data keeps the last result unchanged while out_valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An integer is offered on in_data |
| in_ready | output | 1 | The block can take an integer this cycle |
| in_data | input | 32 | Two's-complement integer to convert |
| out_valid | output | 1 | out_data holds a fresh result this cycle |
| out_data | output | 64 | Converted hex floating-point word |

## Verification
The bench builds the converter with its default parameters: a 32-bit integer, 14 fraction digits and a 7-bit characteristic with offset 64. These values let the bench reach both ends of the signed range, where the biased word is all zeros or all ones. They also let it reach every normalization shift from 6 digits (largest magnitudes) to 13 digits (magnitude 1), and the zero case, where the difference leaves no digit to find. A long run of pseudo-random integers with their scoreboard entries covers the shift amounts between those ends with both signs.

// File: rtl/hexfloat_pkg.sv
package hexfloat_pkg;

    // Default geometry of the long hex floating-point word.
    localparam int DEF_INT_W       = 32;
    localparam int DEF_FRAC_DIGITS = 14;
    localparam int DEF_EXP_W       = 7;
    localparam int DEF_EXP_BIAS    = 64;

    // Progress of one conversion through the block.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,   // waiting for an integer
        PH_SUB  = 2'd1,   // assembled word held, subtract the bias next
        PH_NORM = 2'd2    // difference held, normalize next
    } conv_phase_e;

endpackage

// File: rtl/hf_assemble.sv
// Biases the signed integer by flipping its top bit and places it as an
// unnormalized fraction whose characteristic reads the digits as a whole number.
module hf_assemble #(
    parameter int INT_W       = 32,
    parameter int FRAC_DIGITS = 14,
    parameter int EXP_W       = 7,
    parameter int EXP_BIAS    = 64
) (
    input  logic [INT_W-1:0]         value_i,
    output logic [4*FRAC_DIGITS-1:0] frac_o,
    output logic [EXP_W-1:0]         char_o
);
    localparam int FRAC_W   = 4 * FRAC_DIGITS;
    localparam int ASM_CHAR = EXP_BIAS + FRAC_DIGITS;

    logic [INT_W-1:0] biased;

    always_comb begin
        biased = {~value_i[INT_W-1], value_i[INT_W-2:0]};
        frac_o = FRAC_W'(biased);
        char_o = EXP_W'(ASM_CHAR);
    end

endmodule

// File: rtl/hf_subtract.sv
// Subtracts 2^(INT_W-1) at the assembled characteristic (no alignment needed)
// and returns the difference as sign and magnitude.
module hf_subtract #(
    parameter int INT_W       = 32,
    parameter int FRAC_DIGITS = 14
) (
    input  logic [4*FRAC_DIGITS-1:0] minuend_i,
    output logic                     neg_o,
    output logic [4*FRAC_DIGITS-1:0] mag_o
);
    localparam int FRAC_W = 4 * FRAC_DIGITS;
    localparam logic [FRAC_W-1:0] HALF_RANGE = FRAC_W'(1) << (INT_W - 1);

    logic [FRAC_W:0] diff;

    always_comb begin
        diff  = {1'b0, minuend_i} - {1'b0, HALF_RANGE};
        neg_o = diff[FRAC_W];
        if (diff[FRAC_W]) begin
            mag_o = ~diff[FRAC_W-1:0] + 1'b1;
        end else begin
            mag_o = diff[FRAC_W-1:0];
        end
    end

endmodule

// File: rtl/hf_normalize.sv
// Shifts the magnitude left by whole hex digits until the top digit is nonzero,
// lowering the characteristic once per digit; a zero magnitude becomes true zero.
module hf_normalize #(
    parameter int FRAC_DIGITS = 14,
    parameter int EXP_W       = 7
) (
    input  logic                           sign_i,
    input  logic [EXP_W-1:0]               char_i,
    input  logic [4*FRAC_DIGITS-1:0]       mag_i,
    output logic [4*FRAC_DIGITS+EXP_W:0]   word_o
);
    localparam int FRAC_W = 4 * FRAC_DIGITS;
    localparam int LZ_W   = $clog2(FRAC_DIGITS + 1);

    logic [FRAC_DIGITS-1:0] digit_nz;
    logic [LZ_W-1:0]        lead_zeros;
    logic                   found;
    logic [FRAC_W-1:0]      shifted;
    logic [EXP_W-1:0]       char_adj;

    for (genvar g = 0; g < FRAC_DIGITS; g++) begin : g_digit
        assign digit_nz[g] = |mag_i[4*g +: 4];
    end

    always_comb begin
        lead_zeros = '0;
        found      = 1'b0;
        for (int i = FRAC_DIGITS - 1; i >= 0; i--) begin
            if (!found) begin
                if (digit_nz[i]) begin
                    found = 1'b1;
                end else begin
                    lead_zeros = lead_zeros + 1'b1;
                end
            end
        end
        shifted  = mag_i << {lead_zeros, 2'b00};
        char_adj = char_i - EXP_W'(lead_zeros);
        if (found) begin
            word_o = {sign_i, char_adj, shifted};
        end else begin
            word_o = '0;
        end
    end

endmodule

// File: rtl/int_to_hexfloat.sv
// Signed integer to long hex floating-point converter, three-edge latency.
module int_to_hexfloat
    import hexfloat_pkg::*;
#(
    parameter int INT_W       = DEF_INT_W,
    parameter int FRAC_DIGITS = DEF_FRAC_DIGITS,
    parameter int EXP_W       = DEF_EXP_W,
    parameter int EXP_BIAS    = DEF_EXP_BIAS
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              in_valid,
    output logic                              in_ready,
    input  logic [INT_W-1:0]                  in_data,
    output logic                              out_valid,
    output logic [4*FRAC_DIGITS+EXP_W:0]      out_data
);
    localparam int FRAC_W = 4 * FRAC_DIGITS;
    localparam int WORD_W = FRAC_W + EXP_W + 1;

    typedef struct packed {
        conv_phase_e       phase;
        logic [FRAC_W-1:0] work;
        logic [EXP_W-1:0]  char_val;
        logic              sign;
        logic              out_valid;
        logic [WORD_W-1:0] out_data;
    } conv_state_t;

    conv_state_t st_d, st_q;

    logic [FRAC_W-1:0] asm_frac;
    logic [EXP_W-1:0]  asm_char;
    logic              sub_neg;
    logic [FRAC_W-1:0] sub_mag;
    logic [WORD_W-1:0] norm_word;

    hf_assemble #(
        .INT_W      (INT_W),
        .FRAC_DIGITS(FRAC_DIGITS),
        .EXP_W      (EXP_W),
        .EXP_BIAS   (EXP_BIAS)
    ) u_assemble (
        .value_i(in_data),
        .frac_o (asm_frac),
        .char_o (asm_char)
    );

    hf_subtract #(
        .INT_W      (INT_W),
        .FRAC_DIGITS(FRAC_DIGITS)
    ) u_subtract (
        .minuend_i(st_q.work),
        .neg_o    (sub_neg),
        .mag_o    (sub_mag)
    );

    hf_normalize #(
        .FRAC_DIGITS(FRAC_DIGITS),
        .EXP_W      (EXP_W)
    ) u_normalize (
        .sign_i(st_q.sign),
        .char_i(st_q.char_val),
        .mag_i (st_q.work),
        .word_o(norm_word)
    );

    assign in_ready  = (st_q.phase == PH_IDLE);
    assign out_valid = st_q.out_valid;
    assign out_data  = st_q.out_data;

    always_comb begin
        st_d           = st_q;
        st_d.out_valid = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (in_valid) begin
                    st_d.work     = asm_frac;
                    st_d.char_val = asm_char;
                    st_d.sign     = 1'b0;
                    st_d.phase    = PH_SUB;
                end
            end
            PH_SUB: begin
                st_d.work  = sub_mag;
                st_d.sign  = sub_neg;
                st_d.phase = PH_NORM;
            end
            PH_NORM: begin
                st_d.out_data  = norm_word;
                st_d.out_valid = 1'b1;
                st_d.phase     = PH_IDLE;
            end
            default: begin
                st_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/int_to_hexfloat_checker.sv
module int_to_hexfloat_checker #(
    parameter int WORD_W = 64,
    parameter int FRAC_W = 56
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic [WORD_W-1:0] out_data
);
    logic accept;
    assign accept = in_valid && in_ready;

    // R6: result three edges after acceptance
    p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> ##2 out_valid);

    // R6: every result traces back to an acceptance
    p_origin_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(accept, 3));

    // R6: single-cycle valid pulse
    p_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R7: busy right after acceptance
    p_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !in_ready);

    // R2: nonzero results are normalized
    p_normalized_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (out_data[FRAC_W-1:0] != '0)) |-> (out_data[FRAC_W-1 -: 4] != 4'h0));

    // R4: zero fraction means true zero
    p_true_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (out_data[FRAC_W-1:0] == '0)) |-> (out_data == '0));

    // R9: result held between pulses
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_data));

endmodule

bind int_to_hexfloat int_to_hexfloat_checker #(
    .WORD_W(WORD_W),
    .FRAC_W(FRAC_W)
) u_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_data (out_data)
);

// File: tb/tb_int_to_hexfloat.sv
`timescale 1ns/1ps
module tb_int_to_hexfloat;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        out_valid;
    logic [63:0] out_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [63:0] exp;
        int          due;
        string       req;
    } item_t;

    item_t       sb[$];
    logic [63:0] last_exp = '0;

    always #2.5 clk = ~clk;   // 200 MHz
    always @(posedge clk) cyc <= cyc + 1;

    int_to_hexfloat dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_data  (in_data),
        .out_valid(out_valid),
        .out_data (out_data)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Independent model: direct magnitude and hex-digit normalization.
    function automatic logic [63:0] model(input logic signed [31:0] v);
        longint      m;
        logic        s;
        logic [55:0] f;
        int          ch;
        m = longint'(v);
        s = (m < 0);
        if (s) m = -m;
        if (m == 0) return 64'h0;
        f  = 56'(m);
        ch = 78;
        while (f[55:52] == 4'h0) begin
            f  = f << 4;
            ch = ch - 1;
        end
        return {s, 7'(ch), f};
    endfunction

    function automatic string req_of(input logic signed [31:0] v);
        if (v == 0) return "R4";
        if (v < 0)  return "R3";
        return "R2";
    endfunction

    task automatic send(input logic [31:0] v, input logic [63:0] exp, input string req);
        item_t it;
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = v;
        while (!in_ready) @(negedge clk);
        it.exp = exp;
        it.due = cyc + 3;
        it.req = req;
        sb.push_back(it);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Monitor
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R7 unexpected result", out_data, 64'h0);
            end else begin
                item_t it;
                it = sb.pop_front();
                check(out_data === it.exp, it.req, out_data, it.exp);
                check(cyc == it.due, "R6 latency", 64'(cyc), 64'(it.due));
                last_exp = it.exp;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] lcg;
        repeat (3) @(negedge clk);
        check(in_ready === 1'b1, "R8 in_ready", 64'(in_ready), 64'h1);
        check(out_valid === 1'b0, "R8 out_valid", 64'(out_valid), 64'h0);
        check(out_data === 64'h0, "R8 out_data", out_data, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready === 1'b1 && out_valid === 1'b0, "R8 after release",
              {62'h0, in_ready, out_valid}, 64'h2);

        // R1 layout, R3 sign-magnitude, R4 zero, R5 range ends
        send(32'd59,        64'h423B000000000000, "R1");
        send(-32'sd1,       64'hC110000000000000, "R3");
        send(32'd1,         64'h4110000000000000, "R2");
        send(32'd0,         64'h0000000000000000, "R4");
        send(32'h80000000,  64'hC880000000000000, "R5");
        send(32'h7FFFFFFF,  64'h487FFFFFFF000000, "R5");
        send(-32'sd59,      64'hC23B000000000000, "R3");
        send(32'd16,        model(32'd16), "R2");
        send(32'h10000000,  model(32'h10000000), "R2");
        send(-32'sd16,      model(-32'sd16), "R3");

        // R7: offers while busy are ignored
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = 32'd256;
        while (!in_ready) @(negedge clk);
        begin
            item_t it;
            it.exp = model(32'd256);
            it.due = cyc + 3;
            it.req = "R2";
            sb.push_back(it);
        end
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            in_data = 32'hDEAD0000 + 32'(k);
            check(in_ready === 1'b0, "R7 busy", 64'(in_ready), 64'h0);
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R7 no extra result", 64'(sb.size()), 64'h0);

        // Pseudo-random sweep of both signs
        lcg = 32'h1234ABCD;
        for (int n = 0; n < 150; n++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            send(lcg >> (n % 29), model($signed(lcg >> (n % 29))),
                 req_of($signed(lcg >> (n % 29))));
            send(-(lcg >> (n % 31)), model($signed(-(lcg >> (n % 31)))),
                 req_of($signed(-(lcg >> (n % 31)))));
        end

        repeat (6) @(negedge clk);
        check(sb.size() == 0, "R6 all results seen", 64'(sb.size()), 64'h0);
        check(out_data === last_exp, "R9 hold", out_data, last_exp);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule